// File: doc/BRIEF.md
# Endpoint Buffer CPU Access Port

This block gives a processor access to the packet buffers of a USB device controller's six endpoints. One data register always reaches the control endpoint (endpoint 0). A second, shared data register reaches one of the five data endpoints (1 to 5). Which one it reaches is set by a selection register, and that choice holds until software writes it again. Each of the two access paths has its own control register. That register sets the access width (one byte or two bytes per access) and turns on a count-down view of the bytes not yet read. It also drives the packet lifecycle: commit a partly filled transmit buffer as a short packet, flush a buffer, or commit a zero-length packet.

Each endpoint buffer is a 64-byte internal RAM whose direction is fixed by a parameter. Transmit (IN) buffers are filled by the processor. Once committed, they are handed to the serial side through a ready flag, a length output and a byte-peek port, and they come back when the serial side pulses `ser_done`. Receive (OUT) buffers are filled byte by byte from the serial side and committed with `ser_end`. The processor then drains them, and they free themselves once the last byte has been read. Accesses the buffer cannot honour leave the buffer unchanged and set a sticky error flag for that access path.

Top module: `epq_cpu_port`

## Requirements
- R1: Register address 0 reaches only endpoint 0. Address 1 reaches the endpoint held in the selection register (address 4), which resets to 1. The selection register accepts only the values 1 to 5; any other written value leaves it unchanged. Reading address 4 returns the selection in bits [2:0].
- R2: In 8-bit mode (control bit 2 = 0), a data write stores `cpu_wdata[7:0]` as one byte. A data read returns one byte in `cpu_rdata[7:0]` with `cpu_rdata[15:8]` = 0. Bytes are stored in access order starting at buffer index 0.
- R3: In 16-bit mode (control bit 2 = 1), each data access moves two bytes, the low byte first: the low byte goes to index n and the high byte to n+1. If only one byte is left, a 16-bit read returns it in bits [7:0] with zero in [15:8], and consumes one byte.
- R4: Writing control bit 0 (valid) alone to an IN buffer commits the bytes loaded so far. `buf_ready[e]` becomes 1 and `ser_len` reports that count on the next cycle.
- R5: Writing control bit 1 (clear) without bit 0 empties the targeted buffer. Its length becomes 0 and `buf_ready[e]` becomes 0, for IN and OUT buffers alike.
- R6: Writing bits 0 and 1 together to an IN buffer commits a zero-length packet: `buf_ready[e]` = 1 and `ser_len` = 0.
- R7: Reading a control register (address 2 for endpoint 0, address 3 for the shared path) returns the following fields: length in [15:8], ready in [7], sticky error in [4], count mode in [3] and width in [2]. With count mode (bit 3) set, the length field gives the bytes not yet read; with it clear, it gives the total bytes in the buffer.
- R8: A data write that would take a buffer past 64 bytes, any write to an OUT buffer, any read from an IN buffer, and any read from an uncommitted or empty OUT buffer are all ignored. Such a read returns 0. Each of these sets the path's sticky error bit, which a control write with bit 4 set clears.
- R9: A committed IN buffer rejects data writes (error as in R8) and keeps its contents until `ser_done` is pulsed for that endpoint. That pulse empties the buffer and clears `buf_ready[e]`.
- R10: For an OUT buffer, each `ser_wr` appends `ser_byte` and `ser_end` commits the packet (`buf_ready[e]` = 1). After the processor has read the last byte, the buffer empties and `buf_ready[e]` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 3 | Register address (0 ep0 data, 1 shared data, 2 ep0 control, 3 shared control, 4 select) |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (ignored when `cpu_wr` is high) |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, registered, valid the cycle after `cpu_rd` |
| ser_ep | input | 3 | Endpoint addressed by the serial-side signals |
| ser_wr | input | 1 | Append `ser_byte` to an OUT buffer |
| ser_byte | input | 8 | Received byte |
| ser_end | input | 1 | Commit the received OUT packet |
| ser_done | input | 1 | IN packet consumed; empty the buffer |
| ser_idx | input | PTR_W | Byte index to peek |
| ser_peek | output | 8 | Buffer byte at `ser_idx` of `ser_ep` |
| ser_len | output | CNT_W | Byte count held by `ser_ep` |
| buf_ready | output | 6 | Per-endpoint committed/ready flag |

## Verification
The assertions check on every cycle that a reported length never exceeds the buffer capacity and that the selection changes only on a select write. They also check that control writes to endpoint 0 have their effect on the next cycle (commit, zero-length commit, clear), and that a committed IN buffer stays ready until it is consumed or rewritten. Only the bench scenarios can show the data path itself: byte order in 16-bit mode, the odd-byte tail, the count-down against total length view, rejection with the sticky error at a full buffer, and the automatic release of an OUT buffer once it has been drained.

// File: rtl/epq_pkg.sv
package epq_pkg;

    localparam int NUM_EP       = 6;
    localparam int EP_W         = $clog2(NUM_EP);
    localparam int NUM_PATHS    = 2;

    // Register map of the processor side
    typedef enum logic [2:0] {
        REG_EP0_DATA = 3'd0,
        REG_SHR_DATA = 3'd1,
        REG_EP0_CTRL = 3'd2,
        REG_SHR_CTRL = 3'd3,
        REG_SELECT   = 3'd4
    } reg_addr_e;

    // Control write fields, bits [4:0] of the write data
    typedef struct packed {
        logic err_clr;   // [4]
        logic cnt_mode;  // [3]
        logic wide;      // [2]
        logic clear;     // [1]
        logic valid;     // [0]
    } ctrl_cmd_t;

    // Per-path persistent state
    typedef struct packed {
        logic wide;
        logic cnt_mode;
        logic err;
    } path_mode_t;

    function automatic logic [15:0] status_word(input logic [7:0] len,
                                                input logic ready,
                                                input path_mode_t m);
        return {len, ready, 2'b00, m.err, m.cnt_mode, m.wide, 2'b00};
    endfunction

endpackage

// File: rtl/epq_buffer.sv
module epq_buffer #(
    parameter int BUF_BYTES = 64,
    parameter bit IS_IN     = 1'b1,
    localparam int PTR_W    = $clog2(BUF_BYTES),
    localparam int CNT_W    = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_push,
    input  logic             cpu_pop,
    input  logic             wide,
    input  logic [15:0]      push_word,
    input  logic             commit,
    input  logic             flush,
    input  logic             ser_wr,
    input  logic [7:0]       ser_byte,
    input  logic             ser_end,
    input  logic             ser_done,
    input  logic [PTR_W-1:0] peek_idx,
    output logic [7:0]       peek_byte,
    output logic [15:0]      pop_word,
    output logic [CNT_W-1:0] total,
    output logic [CNT_W-1:0] remain,
    output logic             ready,
    output logic             reject
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(BUF_BYTES);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    logic [7:0]       mem [BUF_BYTES];
    logic [CNT_W-1:0] cnt_q, rptr_q, step, take, left;
    logic             ready_q, can_push, can_pop;
    logic [PTR_W-1:0] wpos, rpos;

    assign step     = wide ? TWO : ONE;
    assign left     = cnt_q - rptr_q;
    assign take     = (wide && left >= TWO) ? TWO : ONE;
    assign wpos     = cnt_q[PTR_W-1:0];
    assign rpos     = rptr_q[PTR_W-1:0];
    assign can_push = IS_IN && !ready_q && (cnt_q + step) <= CAP;
    assign can_pop  = !IS_IN && ready_q && left != '0;
    assign reject   = (cpu_push && !can_push) || (cpu_pop && !can_pop);

    assign pop_word  = {(take == TWO) ? mem[rpos + 1'b1] : 8'h00, mem[rpos]};
    assign peek_byte = mem[peek_idx];
    assign total     = cnt_q;
    assign remain    = left;
    assign ready     = ready_q;

    // Storage write side depends on direction
    if (IS_IN) begin : g_in_store
        always_ff @(posedge clk) begin
            if (cpu_push && can_push) begin
                mem[wpos] <= push_word[7:0];
                if (wide) mem[wpos + 1'b1] <= push_word[15:8];
            end
        end
    end else begin : g_out_store
        always_ff @(posedge clk) begin
            if (ser_wr && !ready_q && cnt_q < CAP) mem[wpos] <= ser_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            rptr_q  <= '0;
            ready_q <= 1'b0;
        end else if (flush) begin
            cnt_q   <= '0;
            rptr_q  <= '0;
            ready_q <= commit && IS_IN;
        end else if (commit && IS_IN) begin
            ready_q <= 1'b1;
        end else if (IS_IN) begin
            if (cpu_push && can_push) begin
                cnt_q <= cnt_q + step;
            end else if (ser_done && ready_q) begin
                cnt_q   <= '0;
                ready_q <= 1'b0;
            end
        end else if (!ready_q) begin
            if (ser_wr && cnt_q < CAP) cnt_q <= cnt_q + ONE;
            if (ser_end) ready_q <= 1'b1;
        end else if (cpu_pop && can_pop) begin
            if (rptr_q + take == cnt_q) begin
                cnt_q   <= '0;
                rptr_q  <= '0;
                ready_q <= 1'b0;
            end else begin
                rptr_q <= rptr_q + take;
            end
        end
    end
endmodule

// File: rtl/epq_path_mode.sv
module epq_path_mode
    import epq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_wr,
    input  ctrl_cmd_t  cmd,
    input  logic       access_reject,
    output path_mode_t mode
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '0;
        end else begin
            if (ctrl_wr) begin
                mode.wide     <= cmd.wide;
                mode.cnt_mode <= cmd.cnt_mode;
            end
            if (access_reject)              mode.err <= 1'b1;
            else if (ctrl_wr && cmd.err_clr) mode.err <= 1'b0;
        end
    end
endmodule

// File: rtl/epq_cpu_port.sv
module epq_cpu_port
    import epq_pkg::*;
#(
    parameter int               BUF_BYTES = 64,
    parameter logic [NUM_EP-1:0] IN_MASK  = 6'b010101,
    localparam int              PTR_W     = $clog2(BUF_BYTES),
    localparam int              CNT_W     = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [15:0]       cpu_wdata,
    output logic [15:0]       cpu_rdata,
    input  logic [EP_W-1:0]   ser_ep,
    input  logic              ser_wr,
    input  logic [7:0]        ser_byte,
    input  logic              ser_end,
    input  logic              ser_done,
    input  logic [PTR_W-1:0]  ser_idx,
    output logic [7:0]        ser_peek,
    output logic [CNT_W-1:0]  ser_len,
    output logic [NUM_EP-1:0] buf_ready
);
    localparam logic [EP_W-1:0] EP_LAST = EP_W'(NUM_EP - 1);

    ctrl_cmd_t              cmd;
    logic [EP_W-1:0]        sel_q;
    logic [EP_W-1:0]        tgt      [NUM_PATHS];
    logic                   dat_wr   [NUM_PATHS];
    logic                   dat_rd   [NUM_PATHS];
    logic                   ctl_wr   [NUM_PATHS];
    logic                   path_rej [NUM_PATHS];
    path_mode_t             mode_q   [NUM_PATHS];
    logic [15:0]            stat_w   [NUM_PATHS];
    logic [15:0]            data_w   [NUM_PATHS];

    logic [NUM_EP-1:0]      ep_push, ep_pop, ep_commit, ep_flush, ep_wide, ep_rej;
    logic [15:0]            ep_word  [NUM_EP];
    logic [7:0]             ep_peek  [NUM_EP];
    logic [CNT_W-1:0]       ep_total [NUM_EP];
    logic [CNT_W-1:0]       ep_left  [NUM_EP];

    assign cmd = ctrl_cmd_t'(cpu_wdata[4:0]);

    // Shared-path endpoint selection, values 1..NUM_EP-1 only
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= EP_W'(1);
        end else if (cpu_wr && cpu_addr == REG_SELECT
                     && cpu_wdata[EP_W-1:0] != '0
                     && cpu_wdata[EP_W-1:0] <= EP_LAST
                     && cpu_wdata[15:EP_W] == '0) begin
            sel_q <= cpu_wdata[EP_W-1:0];
        end
    end

    // Path decode: path 0 is endpoint 0, path 1 the selected endpoint
    always_comb begin
        tgt[0]    = '0;
        tgt[1]    = sel_q;
        dat_wr[0] = cpu_wr && cpu_addr == REG_EP0_DATA;
        dat_wr[1] = cpu_wr && cpu_addr == REG_SHR_DATA;
        dat_rd[0] = cpu_rd && !cpu_wr && cpu_addr == REG_EP0_DATA;
        dat_rd[1] = cpu_rd && !cpu_wr && cpu_addr == REG_SHR_DATA;
        ctl_wr[0] = cpu_wr && cpu_addr == REG_EP0_CTRL;
        ctl_wr[1] = cpu_wr && cpu_addr == REG_SHR_CTRL;
    end

    // Route path operations to the addressed endpoint
    always_comb begin
        for (int e = 0; e < NUM_EP; e++) begin
            int  p;
            logic hit;
            p            = (e == 0) ? 0 : 1;
            hit          = (tgt[p] == EP_W'(e));
            ep_push[e]   = dat_wr[p] && hit;
            ep_pop[e]    = dat_rd[p] && hit;
            ep_commit[e] = ctl_wr[p] && hit && cmd.valid;
            ep_flush[e]  = ctl_wr[p] && hit && cmd.clear;
            ep_wide[e]   = mode_q[p].wide;
        end
        path_rej[0] = ep_rej[0];
        path_rej[1] = |ep_rej[NUM_EP-1:1];
    end

    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        epq_buffer #(.BUF_BYTES(BUF_BYTES), .IS_IN(IN_MASK[e])) u_buf (
            .clk       (clk),
            .rst       (rst),
            .cpu_push  (ep_push[e]),
            .cpu_pop   (ep_pop[e]),
            .wide      (ep_wide[e]),
            .push_word (cpu_wdata),
            .commit    (ep_commit[e]),
            .flush     (ep_flush[e]),
            .ser_wr    (ser_wr   && ser_ep == EP_W'(e)),
            .ser_byte  (ser_byte),
            .ser_end   (ser_end  && ser_ep == EP_W'(e)),
            .ser_done  (ser_done && ser_ep == EP_W'(e)),
            .peek_idx  (ser_idx),
            .peek_byte (ep_peek[e]),
            .pop_word  (ep_word[e]),
            .total     (ep_total[e]),
            .remain    (ep_left[e]),
            .ready     (buf_ready[e]),
            .reject    (ep_rej[e])
        );
    end

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        epq_path_mode u_mode (
            .clk           (clk),
            .rst           (rst),
            .ctrl_wr       (ctl_wr[p]),
            .cmd           (cmd),
            .access_reject (path_rej[p]),
            .mode          (mode_q[p])
        );
        assign stat_w[p] = status_word(
            8'(mode_q[p].cnt_mode ? ep_left[tgt[p]] : ep_total[tgt[p]]),
            buf_ready[tgt[p]], mode_q[p]);
        assign data_w[p] = ep_rej[tgt[p]] ? 16'h0000 : ep_word[tgt[p]];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_rdata <= '0;
        end else if (cpu_rd && !cpu_wr) begin
            case (cpu_addr)
                REG_EP0_DATA: cpu_rdata <= data_w[0];
                REG_SHR_DATA: cpu_rdata <= data_w[1];
                REG_EP0_CTRL: cpu_rdata <= stat_w[0];
                REG_SHR_CTRL: cpu_rdata <= stat_w[1];
                REG_SELECT:   cpu_rdata <= 16'(sel_q);
                default:      cpu_rdata <= '0;
            endcase
        end
    end

    assign ser_peek = (ser_ep <= EP_LAST) ? ep_peek[ser_ep]  : 8'h00;
    assign ser_len  = (ser_ep <= EP_LAST) ? ep_total[ser_ep] : '0;
endmodule

// File: rtl/epq_checker.sv
module epq_checker
    import epq_pkg::*;
#(
    parameter int  BUF_BYTES = 64,
    localparam int CNT_W     = $clog2(BUF_BYTES) + 1
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        cpu_addr,
    input logic              cpu_wr,
    input logic [15:0]       cpu_wdata,
    input logic [EP_W-1:0]   ser_ep,
    input logic              ser_done,
    input logic [CNT_W-1:0]  ser_len,
    input logic [NUM_EP-1:0] buf_ready,
    input logic [EP_W-1:0]   sel_q,
    input logic [NUM_EP-1:0] in_mask
);
    logic ep0_ctl;
    assign ep0_ctl = cpu_wr && cpu_addr == REG_EP0_CTRL;

    // R8: no buffer ever reports more than its capacity
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        ser_len <= CNT_W'(BUF_BYTES));

    // R1: the selection only moves on a select write
    p_select_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !(cpu_wr && cpu_addr == REG_SELECT) |=> $stable(sel_q));

    // R4: valid alone commits an IN buffer
    p_commit_r4: assert property (@(posedge clk) disable iff (rst)
        (ep0_ctl && cpu_wdata[1:0] == 2'b01 && in_mask[0]) |=> buf_ready[0]);

    // R5: clear alone drops the ready flag
    p_clear_empties_r5: assert property (@(posedge clk) disable iff (rst)
        (ep0_ctl && cpu_wdata[1:0] == 2'b10) |=> !buf_ready[0]);

    // R6: valid with clear gives a ready, zero-length packet
    p_zero_len_r6: assert property (@(posedge clk) disable iff (rst)
        (ep0_ctl && cpu_wdata[1:0] == 2'b11 && in_mask[0])
        |=> buf_ready[0] && (ser_ep != '0 || ser_len == '0));

    // R9: a committed IN buffer stays ready until consumed or rewritten
    p_commit_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (in_mask[0] && buf_ready[0] && !(ser_done && ser_ep == '0) && !ep0_ctl)
        |=> buf_ready[0]);
endmodule

bind epq_cpu_port epq_checker #(.BUF_BYTES(BUF_BYTES)) u_epq_checker (
    .clk       (clk),
    .rst       (rst),
    .cpu_addr  (cpu_addr),
    .cpu_wr    (cpu_wr),
    .cpu_wdata (cpu_wdata),
    .ser_ep    (ser_ep),
    .ser_done  (ser_done),
    .ser_len   (ser_len),
    .buf_ready (buf_ready),
    .sel_q     (sel_q),
    .in_mask   (IN_MASK)
);

// File: tb/test_epq_cpu_port.sv
`timescale 1ns/100ps
module test_epq_cpu_port;
    localparam int A_EP0D = 0, A_SHRD = 1, A_EP0C = 2, A_SHRC = 3, A_SEL = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cpu_addr = '0;
    logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic [2:0]  ser_ep = '0;
    logic        ser_wr = 1'b0, ser_end = 1'b0, ser_done = 1'b0;
    logic [7:0]  ser_byte = '0;
    logic [5:0]  ser_idx = '0;
    logic [7:0]  ser_peek;
    logic [6:0]  ser_len;
    logic [5:0]  buf_ready;

    int checks = 0, fails = 0;
    bit finished = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    epq_cpu_port i_epq_cpu_port (.*);

    // Monitor: compare registered read data against the scoreboard
    always @(posedge clk) rd_seen <= cpu_rd && !cpu_wr;
    always @(negedge clk) begin
        if (rd_seen) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL read: unexpected result %h", cpu_rdata);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (cpu_rdata !== e) begin
                    fails++;
                    $display("FAIL %s: got %h expected %h", t, cpu_rdata, e);
                end
            end
        end
    end

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string t);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", t, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        cpu_addr = 3'(a); cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd(input int a, input logic [15:0] exp, input string t);
        cpu_addr = 3'(a); cpu_rd = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(t);
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic ser_push(input int ep, input logic [7:0] b);
        ser_ep = 3'(ep); ser_byte = b; ser_wr = 1'b1;
        @(negedge clk);
        ser_wr = 1'b0;
    endtask

    task automatic ser_pulse(input int ep, input bit is_end);
        ser_ep = 3'(ep);
        if (is_end) ser_end = 1'b1; else ser_done = 1'b1;
        @(negedge clk);
        ser_end = 1'b0; ser_done = 1'b0;
    endtask

    task automatic peek(input int ep, input int idx, input logic [7:0] exp, input string t);
        ser_ep = 3'(ep); ser_idx = 6'(idx);
        @(negedge clk);
        chk({8'h00, ser_peek}, {8'h00, exp}, t);
    endtask

    task automatic len_is(input int ep, input int exp, input string t);
        ser_ep = 3'(ep);
        @(negedge clk);
        chk({9'h000, ser_len}, 16'(exp), t);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state
        rd(A_SEL, 16'h0001, "R1 reset selection");
        rd(A_EP0C, 16'h0000, "R8 reset status");
        chk({10'h0, buf_ready}, 16'h0000, "R4 reset ready flags");

        // Endpoint 0, byte mode, short packet
        wr(A_EP0C, 16'h0000);
        wr(A_EP0D, 16'hAB11);
        wr(A_EP0D, 16'hCD22);
        rd(A_EP0C, 16'h0200, "R7 total length before commit");
        chk({15'h0, buf_ready[0]}, 16'h0, "R4 not ready before valid");
        wr(A_EP0C, 16'h0001);
        chk({15'h0, buf_ready[0]}, 16'h1, "R4 ready after valid");
        len_is(0, 2, "R4 committed length");
        peek(0, 0, 8'h11, "R2 byte 0");
        peek(0, 1, 8'h22, "R2 byte 1");

        // Committed buffer refuses writes until consumed
        wr(A_EP0D, 16'h0033);
        rd(A_EP0C, 16'h0290, "R9 write to committed buffer flagged");
        len_is(0, 2, "R9 committed contents kept");
        ser_pulse(0, 1'b0);
        chk({15'h0, buf_ready[0]}, 16'h0, "R9 ready cleared by done");
        len_is(0, 0, "R9 emptied by done");
        wr(A_EP0C, 16'h0010);
        rd(A_EP0C, 16'h0000, "R8 error cleared");

        // Shared path, word mode, endpoint 2
        wr(A_SEL, 16'h0002);
        rd(A_SEL, 16'h0002, "R1 selection written");
        wr(A_SHRC, 16'h0004);
        wr(A_SHRD, 16'h3412);
        wr(A_SHRD, 16'h7856);
        wr(A_SHRC, 16'h0005);
        len_is(2, 4, "R3 word length");
        peek(2, 0, 8'h12, "R3 low byte first");
        peek(2, 1, 8'h34, "R3 high byte second");
        peek(2, 2, 8'h56, "R3 second word low");
        peek(2, 3, 8'h78, "R3 second word high");

        // Zero-length packet on endpoint 4
        wr(A_SEL, 16'h0004);
        wr(A_SHRC, 16'h0003);
        chk({15'h0, buf_ready[4]}, 16'h1, "R6 zero-length ready");
        len_is(4, 0, "R6 zero length");

        // Clear a committed buffer
        wr(A_SEL, 16'h0002);
        wr(A_SHRC, 16'h0002);
        chk({15'h0, buf_ready[2]}, 16'h0, "R5 clear drops ready");
        len_is(2, 0, "R5 clear empties");

        // OUT endpoint 1: word reads, odd tail, count-down
        ser_push(1, 8'hA1);
        ser_push(1, 8'hA2);
        ser_push(1, 8'hA3);
        ser_pulse(1, 1'b1);
        chk({15'h0, buf_ready[1]}, 16'h1, "R10 received packet ready");
        wr(A_SEL, 16'h0001);
        wr(A_SHRC, 16'h000C);
        rd(A_SHRC, 16'h038C, "R7 remaining before reads");
        rd(A_SHRD, 16'hA2A1, "R3 word read low first");
        rd(A_SHRC, 16'h018C, "R7 remaining counts down");
        rd(A_SHRD, 16'h00A3, "R3 odd tail zero-filled");
        chk({15'h0, buf_ready[1]}, 16'h0, "R10 drained buffer released");
        rd(A_SHRC, 16'h000C, "R10 drained length zero");
        rd(A_SHRD, 16'h0000, "R8 read of empty buffer");
        rd(A_SHRC, 16'h001C, "R8 empty read flagged");
        wr(A_SHRC, 16'h0010);
        rd(A_SHRC, 16'h0000, "R8 shared error cleared");

        // OUT endpoint 3: total length view vs count-down view
        for (int i = 1; i <= 5; i++) ser_push(3, 8'(i));
        ser_pulse(3, 1'b1);
        wr(A_SEL, 16'h0003);
        wr(A_SHRC, 16'h0000);
        rd(A_SHRD, 16'h0001, "R2 byte read");
        rd(A_SHRC, 16'h0580, "R7 total view");
        wr(A_SHRC, 16'h0008);
        rd(A_SHRC, 16'h0488, "R7 remaining view");
        wr(A_SHRC, 16'h000A);
        chk({15'h0, buf_ready[3]}, 16'h0, "R5 clear on OUT buffer");
        rd(A_SHRC, 16'h0008, "R5 OUT length zero after clear");

        // Capacity on endpoint 0
        wr(A_EP0C, 16'h0000);
        for (int i = 0; i < 64; i++) wr(A_EP0D, 16'(i));
        rd(A_EP0C, 16'h4000, "R8 full buffer length");
        wr(A_EP0D, 16'h00FF);
        rd(A_EP0C, 16'h4010, "R8 overflow flagged");
        wr(A_EP0C, 16'h0001);
        len_is(0, 64, "R8 length kept at capacity");
        peek(0, 63, 8'h3F, "R8 last byte intact");
        ser_pulse(0, 1'b0);

        // Invalid selections ignored
        wr(A_SEL, 16'h0007);
        rd(A_SEL, 16'h0003, "R1 select 7 ignored");
        wr(A_SEL, 16'h0000);
        rd(A_SEL, 16'h0003, "R1 select 0 ignored");

        // Write to an OUT buffer through the shared path
        wr(A_SHRD, 16'h0055);
        rd(A_SHRC, 16'h0018, "R8 write to OUT flagged");

        // Endpoint 0 register stays on endpoint 0
        wr(A_EP0C, 16'h0010);
        wr(A_EP0D, 16'h0009);
        len_is(0, 1, "R1 ep0 register reaches ep0");
        len_is(3, 0, "R1 selected endpoint untouched");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule